// File: doc/BRIEF.md
# System Clock Gear Controller

This block owns the system clock control byte and the logic behind it. It turns the free-running oscillator clock into two clock-enable strobes. The first is an instruction-clock enable for the CPU and the peripherals. It pulses once every 4, 8, 16 or 64 oscillator cycles, and the ratio, called the gear, is chosen by software. The second is a time-base enable that is high on every cycle while the oscillator is running and does not depend on the gear.

The block also tracks the oscillator through three states:

- `OSC_WAIT`: waiting for the oscillator to stabilise.
- `OSC_RUN`: active mode.
- `OSC_STOP`: stopped.

The state moves along these named transitions:

- **reset entry**: reset puts the block in `OSC_WAIT`.
- **wait done**: `OSC_WAIT` goes to `OSC_RUN` when the stabilisation counter expires.
- **stop entry**: `OSC_RUN` goes to `OSC_STOP` on a stop request.
- **wake entry**: `OSC_STOP` goes to `OSC_WAIT` on a wake interrupt.

A read-only status bit reads 1 only in `OSC_RUN`. Software should check it before it changes the wait selection. The wait length applied after reset is taken from a strap input. The wait length applied after a wake is taken from the register's wait field.

Top module: `sysgear_ctrl`

## Requirements
- R1: While reset is held and just after it, `rdata` reads `{0, 00, wait_opt, 1, 00}`. This means the status bit is 0, the wait field equals `wait_opt`, and the gear field is 00. The status bit reads 1 exactly 2^WLOG[wait_opt] clock edges after reset is released.
- R2: The gear field `rdata[1:0]` sets the `inst_ce` period in `OSC_RUN`: 00 gives 64 cycles, 01 gives 16, 10 gives 8 and 11 gives 4.
- R3: A new gear takes effect only at the next `inst_ce` pulse. The interval in progress keeps its old length, so no shortened period is produced.
- R4: `rdata[7]` reads 1 in `OSC_RUN` and 0 in `OSC_STOP` and `OSC_WAIT`. Writing `wdata[7]` has no effect on it.
- R5: A stop request sampled in `OSC_RUN` makes `rdata[7]`, `inst_ce` and `tbt_ce` all 0 from the next cycle. They stay 0 until the wake sequence completes.
- R6: After a wake interrupt in `OSC_STOP`, the block re-enters `OSC_RUN` exactly 2^WLOG[sel] edges after the wake edge. Here sel is the wait field `rdata[4:3]` at the time of the wake.
- R7: The wait field maps 00 to 2^2, 01 to 2^12, 10 to 2^15 and 11 to 2^17 oscillator cycles.
- R8: `rdata[2]` always reads 1 and `rdata[6:5]` always read 0, whatever is written to those bits.
- R9: `tbt_ce` is high on every cycle of `OSC_RUN`, whatever the gear.
- R10: A wake interrupt outside `OSC_STOP` is ignored, and so is a stop request outside `OSC_RUN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| stop_req | input | 1 | Request to enter stop mode |
| wake_irq | input | 1 | External interrupt that wakes the block from stop |
| wait_opt | input | 2 | Strap for the wait selection after reset |
| inst_ce | output | 1 | CPU and peripheral clock enable, divided by the gear |
| tbt_ce | output | 1 | Undivided time-base clock enable |

## Verification
Every result of this block is registered once. A write, a stop request or a wake is driven just after a falling edge and is sampled at the next rising edge. Its effect on `rdata`, `tbt_ce` and the state is therefore visible at the following falling edge. A gear write changes the `inst_ce` spacing only from the pulse after that edge. A wait of L cycles ends L rising edges after the wake edge, or after the reset release. The bench runs a behavioural model that advances on the same rising edges and compares every output at each falling edge. Directed checks count falling edges between pulses and up to the status rise, and compare those counts with the values in the requirements.

// File: rtl/sysgear_pkg.sv
package sysgear_pkg;
    typedef enum logic [1:0] {
        OSC_STOP = 2'd0,
        OSC_WAIT = 2'd1,
        OSC_RUN  = 2'd2
    } osc_state_e;

    localparam int GEAR_W = 2;
    localparam int WSEL_W = 2;
    localparam int NSEL   = 4;
endpackage

// File: rtl/sysgear_regs.sv
module sysgear_regs
    import sysgear_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic [WSEL_W-1:0] wait_opt,
    input  logic              status,
    output logic [GEAR_W-1:0] gear,
    output logic [WSEL_W-1:0] wsel,
    output logic [7:0]        rdata
);
    logic [GEAR_W-1:0] gear_q;
    logic [WSEL_W-1:0] wsel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gear_q <= '0;
            wsel_q <= wait_opt;
        end else if (wr_en) begin
            gear_q <= wdata[1:0];
            wsel_q <= wdata[4:3];
        end
    end

    assign gear  = gear_q;
    assign wsel  = wsel_q;
    assign rdata = {status, 2'b00, wsel_q, 1'b1, gear_q};
endmodule

// File: rtl/sysgear_prescaler.sv
module sysgear_prescaler
    import sysgear_pkg::*;
#(
    parameter int DIV_G0 = 64,
    parameter int DIV_G1 = 16,
    parameter int DIV_G2 = 8,
    parameter int DIV_G3 = 4,
    parameter int PCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [GEAR_W-1:0] gear_req,
    output logic              inst_ce
);
    localparam int DIV_TAB [NSEL] = '{DIV_G0, DIV_G1, DIV_G2, DIV_G3};

    logic [GEAR_W-1:0] act_gear;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] plim;
    logic              edge_hit;

    always_comb begin
        plim     = PCNT_W'(DIV_TAB[act_gear] - 1);
        edge_hit = (pcnt == plim);
    end

    // Gear is adopted only at a period boundary or while not running.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt     <= '0;
            act_gear <= '0;
        end else if (!run || edge_hit) begin
            pcnt     <= '0;
            act_gear <= gear_req;
        end else begin
            pcnt     <= pcnt + 1'b1;
        end
    end

    assign inst_ce = run && edge_hit;
endmodule

// File: rtl/sysgear_osc_fsm.sv
module sysgear_osc_fsm
    import sysgear_pkg::*;
#(
    parameter int WLOG_0 = 2,
    parameter int WLOG_1 = 12,
    parameter int WLOG_2 = 15,
    parameter int WLOG_3 = 17,
    parameter int WCNT_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_req,
    input  logic              wake_irq,
    input  logic [WSEL_W-1:0] wait_opt,
    input  logic [WSEL_W-1:0] wsel_reg,
    output logic              running
);
    localparam int WLOG_TAB [NSEL] = '{WLOG_0, WLOG_1, WLOG_2, WLOG_3};

    osc_state_e        state_q, state_d;
    logic [WCNT_W-1:0] wcnt_q, wcnt_d;
    logic [WSEL_W-1:0] sel_q, sel_d;
    logic [WCNT_W-1:0] wait_last;

    always_comb begin
        wait_last = WCNT_W'((1 << WLOG_TAB[sel_q]) - 1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OSC_WAIT;
            wcnt_q  <= '0;
            sel_q   <= wait_opt;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
            sel_q   <= sel_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        sel_d   = sel_q;
        unique case (state_q)
            OSC_RUN: begin
                if (stop_req) state_d = OSC_STOP;
            end
            OSC_WAIT: begin
                if (wcnt_q == wait_last) state_d = OSC_RUN;
                else                     wcnt_d  = wcnt_q + 1'b1;
            end
            OSC_STOP: begin
                if (wake_irq) begin
                    state_d = OSC_WAIT;
                    wcnt_d  = '0;
                    sel_d   = wsel_reg;
                end
            end
            default: state_d = OSC_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        running = (state_q == OSC_RUN);
    end
endmodule

// File: rtl/sysgear_ctrl.sv
module sysgear_ctrl
    import sysgear_pkg::*;
#(
    parameter int DIV_G0 = 64,
    parameter int DIV_G1 = 16,
    parameter int DIV_G2 = 8,
    parameter int DIV_G3 = 4,
    parameter int WLOG_0 = 2,
    parameter int WLOG_1 = 12,
    parameter int WLOG_2 = 15,
    parameter int WLOG_3 = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       stop_req,
    input  logic       wake_irq,
    input  logic [1:0] wait_opt,
    output logic       inst_ce,
    output logic       tbt_ce
);
    localparam int DIV_MAX01 = (DIV_G0 > DIV_G1) ? DIV_G0 : DIV_G1;
    localparam int DIV_MAX23 = (DIV_G2 > DIV_G3) ? DIV_G2 : DIV_G3;
    localparam int DIV_MAX   = (DIV_MAX01 > DIV_MAX23) ? DIV_MAX01 : DIV_MAX23;
    localparam int PCNT_W    = $clog2(DIV_MAX);
    localparam int WLOG_M01  = (WLOG_0 > WLOG_1) ? WLOG_0 : WLOG_1;
    localparam int WLOG_M23  = (WLOG_2 > WLOG_3) ? WLOG_2 : WLOG_3;
    localparam int WCNT_W    = (WLOG_M01 > WLOG_M23) ? WLOG_M01 : WLOG_M23;

    logic              running;
    logic [GEAR_W-1:0] gear;
    logic [WSEL_W-1:0] wsel;

    sysgear_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (wdata),
        .wait_opt (wait_opt),
        .status   (running),
        .gear     (gear),
        .wsel     (wsel),
        .rdata    (rdata)
    );

    sysgear_osc_fsm #(
        .WLOG_0 (WLOG_0), .WLOG_1 (WLOG_1),
        .WLOG_2 (WLOG_2), .WLOG_3 (WLOG_3),
        .WCNT_W (WCNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .wake_irq (wake_irq),
        .wait_opt (wait_opt),
        .wsel_reg (wsel),
        .running  (running)
    );

    sysgear_prescaler #(
        .DIV_G0 (DIV_G0), .DIV_G1 (DIV_G1),
        .DIV_G2 (DIV_G2), .DIV_G3 (DIV_G3),
        .PCNT_W (PCNT_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .gear_req (gear),
        .inst_ce  (inst_ce)
    );

    assign tbt_ce = running;
endmodule

// File: rtl/sysgear_chk.sv
module sysgear_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rdata,
    input logic       stop_req,
    input logic       inst_ce,
    input logic       tbt_ce
);
    // R8
    rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[2] == 1'b1) && (rdata[6:5] == 2'b00));

    // R5
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[7] && stop_req) |=> (!rdata[7] && !tbt_ce && !inst_ce));

    // R5
    ce_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inst_ce |-> tbt_ce);

    // R2
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inst_ce |=> !inst_ce);

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[7] && !stop_req) |=> rdata[7]);
endmodule

bind sysgear_ctrl sysgear_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (rdata),
    .stop_req (stop_req),
    .inst_ce  (inst_ce),
    .tbt_ce   (tbt_ce)
);

// File: tb/sysgear_ctrl_tb.sv
`timescale 1ns/1ps
module sysgear_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       stop_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic [1:0] wait_opt = 2'b00;
    logic       inst_ce;
    logic       tbt_ce;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sysgear_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wdata (wdata),
        .rdata (rdata), .stop_req (stop_req), .wake_irq (wake_irq),
        .wait_opt (wait_opt), .inst_ce (inst_ce), .tbt_ce (tbt_ce)
    );

    function automatic int gdiv(input int g);
        case (g)
            0: return 64;
            1: return 16;
            2: return 8;
            default: return 4;
        endcase
    endfunction

    function automatic int wlen_of(input int s);
        case (s)
            0: return 4;
            1: return 4096;
            2: return 32768;
            default: return 131072;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: 0 stop, 1 wait, 2 run
    int m_st, m_wcnt, m_wlen, m_cs, m_wt, m_ph, m_dv;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 1; m_wcnt = 0; m_wlen = wlen_of(int'(wait_opt));
            m_cs = 0; m_wt = int'(wait_opt); m_ph = 0; m_dv = 64;
        end else begin
            int ocs, owt;
            ocs = m_cs; owt = m_wt;
            if (wr_en) begin m_cs = int'(wdata[1:0]); m_wt = int'(wdata[4:3]); end
            if (m_st == 2) begin
                if (m_ph == m_dv - 1) begin m_ph = 0; m_dv = gdiv(ocs); end
                else m_ph++;
            end else begin
                m_ph = 0; m_dv = gdiv(ocs);
            end
            case (m_st)
                2: if (stop_req) m_st = 0;
                1: if (m_wcnt == m_wlen - 1) m_st = 2; else m_wcnt++;
                default: if (wake_irq) begin m_st = 1; m_wcnt = 0; m_wlen = wlen_of(owt); end
            endcase
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(rdata[7] == (m_st == 2), "R4 status", rdata[7], m_st == 2);
            check(rdata[1:0] == m_cs[1:0] && rdata[4:3] == m_wt[1:0], "R1 fields",
                  rdata, {m_wt[1:0], 1'b1, m_cs[1:0]});
            check(rdata[2] == 1'b1 && rdata[6:5] == 2'b00, "R8 fixed bits", rdata, 4);
            check(inst_ce == (m_st == 2 && m_ph == m_dv - 1), "R3 inst_ce", inst_ce,
                  m_st == 2 && m_ph == m_dv - 1);
            check(tbt_ce == (m_st == 2), "R9 tbt_ce", tbt_ce, m_st == 2);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1; wdata = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(output int p);
        while (!inst_ce) @(negedge clk);
        p = 0;
        do begin @(negedge clk); p++; end while (!inst_ce);
    endtask

    task automatic wait_active(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!rdata[7]);
    endtask

    task automatic do_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int p, n;
        tick(3);
        // R1 reset value
        check(rdata == 8'h04, "R1 reset rdata", rdata, 8'h04);
        rst_n = 1'b1;
        wait_active(n);
        check(n == 4, "R1 reset wait", n, 4);

        // R2 gear periods
        for (int g = 0; g < 4; g++) begin
            wr(8'h04 | 8'(g));
            measure(p);
            measure(p);
            check(p == gdiv(g), "R2 period", p, gdiv(g));
        end

        // R3 switch 64 -> 4 mid period
        wr(8'h04);
        measure(p); measure(p);
        while (!inst_ce) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 2) begin wr_en = 1'b1; wdata = 8'h07; end
            else wr_en = 1'b0;
        end while (!inst_ce);
        wr_en = 1'b0;
        check(n == 64, "R3 old period kept", n, 64);
        measure(p);
        check(p == 4, "R3 new period", p, 4);

        // R8 and R4: reserved bits and status write
        wr(8'h67);
        check(rdata[6:5] == 2'b00 && rdata[2], "R8 reserved", rdata, 8'h87);
        check(rdata[7] == 1'b1, "R4 status kept", rdata[7], 1);
        check(tbt_ce == 1'b1, "R9 tbt high", tbt_ce, 1);

        // R10 wake while running
        wake_irq = 1'b1; tick(1); wake_irq = 1'b0; tick(1);
        check(rdata[7] == 1'b1, "R10 wake ignored", rdata[7], 1);

        // R5 stop
        do_stop();
        check(rdata[7] == 1'b0 && !tbt_ce && !inst_ce, "R5 stop", rdata, 0);
        wr(8'h87);
        check(rdata[7] == 1'b0, "R4 status write ignored", rdata[7], 0);
        do_stop();
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (inst_ce || tbt_ce) n++;
        end
        check(n == 0, "R5 gated", n, 0);

        // R6 wake with wait 00
        wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
        wait_active(n);
        check(n == 4, "R6 wake wait", n, 4);

        // R7 wait 01 with a stop request during the wait (R10)
        wr(8'h0F);
        do_stop();
        wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
        do_stop();
        wait_active(n);
        check(n + 1 == 4096, "R7 wait 01", n + 1, 4096);

        // R7 wait 10
        wr(8'h17);
        do_stop();
        wake_irq = 1'b1; @(negedge clk); wake_irq = 1'b0;
        wait_active(n);
        check(n == 32768, "R7 wait 10", n, 32768);
        measure(p); measure(p);
        check(p == 4, "R2 gear after wake", p, 4);

        finish_run();
    end
endmodule